// File: doc/BRIEF.md
# 1-Wire Transaction Sequencer

This controller runs one complete 1-Wire bus transaction on top of a separate bit-slot engine that owns all slot timing. A single start strobe launches the transaction. If a reset is requested, the sequencer first issues a bus reset and checks the presence result. It then hands the engine one slot stream. That stream holds the command bytes followed by as many all-ones read slots as the caller wants response bytes. When the engine reports the transfer done, the sequencer walks the engine's capture buffer from a caller-chosen bit offset and packs the captured bits into response bytes.

Reads and writes share one transfer. Response data is therefore located by bit position in the capture buffer. For example, an 8-byte identifier returned after a 2-byte command starts at slot 16. If no device answers a reset, the transaction stops early and raises a no-device error. A successful extraction raises a data-ready flag that holds until the caller clears it or starts again.

Top module: `owseq_top`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `no_device`, `eng_reset_go` and `eng_xfer_go` are all low and `rsp_data` is zero.
- R2: When `want_reset` is high at an accepted start, exactly one single-cycle `eng_reset_go` pulse is issued and the transfer waits for `eng_done`. When `want_reset` is low, no reset pulse is issued and `eng_presence` is ignored.
- R3: If a reset was issued and `eng_presence` is low when `eng_done` returns, no transfer is launched, `no_device` rises, `rsp_valid` stays low and the sequencer returns to idle.
- R4: `eng_slot_count` is 8*(cmd_len+rd_len), limited to 128. Slot i carries `cmd_data[i]` for i < 8*cmd_len, so byte j occupies bits [8j+7:8j] and goes out LSB first. Every later slot is a 1 (read slot).
- R5: Bit k of `rsp_data` equals capture slot rd_offset+k, so response byte j sits in bits [8j+7:8j] with its LSB captured first. Bits not extracted are 0.
- R6: Extraction covers min(8*rd_len, 128-rd_offset) slots and never reads past slot 127.
- R7: `rsp_valid` rises when extraction ends and stays high until `clear_ready` or the next accepted start.
- R8: A start pulse while `busy` is high is ignored. The running transaction keeps the parameters latched at its own start.
- R9: `rsp_valid` and `no_device` are never high together, and both are low in the cycle after an accepted start.
- R10: `busy` is high from the cycle after an accepted start until the transaction ends in either the error or the data-ready outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only when idle |
| want_reset | input | 1 | Issue a bus reset and presence check first |
| cmd_data | input | CMD_MAX*8 | Command bytes, byte 0 in the low bits |
| cmd_len | input | $clog2(CMD_MAX+1) | Number of command bytes |
| rd_len | input | $clog2(RD_MAX+1) | Number of response bytes wanted |
| rd_offset | input | $clog2(BUF_SLOTS) | First capture slot of the response |
| clear_ready | input | 1 | Clears the data-ready flag |
| eng_done | input | 1 | Engine idle or finished |
| eng_presence | input | 1 | Presence seen in the last reset |
| eng_slot_idx | input | $clog2(BUF_SLOTS) | Slot the engine is fetching |
| cap_bit | input | 1 | Captured bit at `cap_addr` |
| eng_reset_go | output | 1 | Launch a bus reset |
| eng_xfer_go | output | 1 | Launch the slot transfer |
| eng_slot_count | output | $clog2(BUF_SLOTS)+1 | Slots in the transfer |
| eng_slot_bit | output | 1 | Value of slot `eng_slot_idx` |
| cap_addr | output | $clog2(BUF_SLOTS) | Capture slot being read |
| rsp_data | output | RD_MAX*8 | Assembled response bytes |
| rsp_valid | output | 1 | Data ready (sticky) |
| no_device | output | 1 | No presence after reset |
| busy | output | 1 | Transaction in progress |

## Verification
The assertions assume the engine lowers `eng_done` at the clock edge that samples a launch pulse and keeps it low until the reset or transfer finishes. They also assume `eng_presence` is valid whenever `eng_done` is high after a reset. The bench's engine model follows exactly this handshake: it drops done at the launch edge, runs a fixed reset delay or fetches one slot per cycle, and then raises done. Capture content is modelled as the sent slot ANDed with a per-transaction device pattern, so read slots return device data and written ones echo. Command and read lengths stay within the configured maxima, and the offset sweep reaches the last slot of the buffer.

// File: rtl/owseq_pkg.sv
package owseq_pkg;

    typedef enum logic [1:0] {
        SQ_OFF   = 2'd0,
        SQ_RESET = 2'd1,
        SQ_SEND  = 2'd2,
        SQ_READ  = 2'd3
    } seq_state_e;

    // Number of slots available from 'first' when 'want' are asked for
    // in a buffer of 'limit' slots.
    function automatic int clip_span(input int first, input int want, input int limit);
        if (first >= limit)
            return 0;
        if (want > limit - first)
            return limit - first;
        return want;
    endfunction

endpackage

// File: rtl/owseq_slot_feed.sv
module owseq_slot_feed #(
    parameter int BUF_SLOTS = 128,
    parameter int CMD_MAX   = 4,
    parameter int RD_MAX    = 8,
    parameter int IDX_W     = $clog2(BUF_SLOTS),
    parameter int CNT_W     = IDX_W + 1,
    parameter int CL_W      = $clog2(CMD_MAX + 1),
    parameter int RL_W      = $clog2(RD_MAX + 1)
) (
    input  logic [CMD_MAX*8-1:0] cmd_q,
    input  logic [CL_W-1:0]      cmd_len_q,
    input  logic [RL_W-1:0]      rd_len_q,
    input  logic [IDX_W-1:0]     slot_idx,
    output logic                 slot_bit,
    output logic [CNT_W-1:0]     slot_count
);
    import owseq_pkg::*;

    logic cmd_pick;

    always_comb begin
        cmd_pick = 1'b0;
        for (int i = 0; i < CMD_MAX*8; i++)
            if (slot_idx == IDX_W'(i))
                cmd_pick = cmd_q[i];
    end

    // Command region first, then read slots driven as ones.
    assign slot_bit   = (int'(slot_idx) < 8 * int'(cmd_len_q)) ? cmd_pick : 1'b1;
    assign slot_count = CNT_W'(clip_span(0, 8 * (int'(cmd_len_q) + int'(rd_len_q)), BUF_SLOTS));

endmodule

// File: rtl/owseq_gather.sv
module owseq_gather #(
    parameter int BUF_SLOTS = 128,
    parameter int RD_MAX    = 8,
    parameter int IDX_W     = $clog2(BUF_SLOTS),
    parameter int CNT_W     = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wipe,
    input  logic                launch,
    input  logic [IDX_W-1:0]    first,
    input  logic [CNT_W-1:0]    span,
    input  logic                cap_bit,
    output logic [IDX_W-1:0]    cap_addr,
    output logic [RD_MAX*8-1:0] rsp,
    output logic                finish
);
    logic             active;
    logic [IDX_W-1:0] pos;
    logic [CNT_W-1:0] got;
    logic [CNT_W-1:0] want;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pos    <= '0;
            got    <= '0;
            want   <= '0;
            rsp    <= '0;
        end else if (wipe) begin
            active <= 1'b0;
            rsp    <= '0;
        end else if (launch) begin
            active <= 1'b1;
            pos    <= first;
            got    <= '0;
            want   <= span;
        end else if (active) begin
            if (got == want) begin
                active <= 1'b0;
            end else begin
                for (int b = 0; b < RD_MAX*8; b++)
                    if (got == CNT_W'(b))
                        rsp[b] <= cap_bit;
                pos <= pos + 1'b1;
                got <= got + 1'b1;
            end
        end
    end

    assign cap_addr = pos;
    assign finish   = active && (got == want);

endmodule

// File: rtl/owseq_fsm.sv
module owseq_fsm (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic want_reset,
    input  logic clear_ready,
    input  logic eng_done,
    input  logic eng_presence,
    input  logic gather_finish,
    output logic accept,
    output logic launch,
    output logic eng_reset_go,
    output logic eng_xfer_go,
    output logic busy,
    output logic rsp_valid,
    output logic no_device
);
    import owseq_pkg::*;

    seq_state_e state;
    logic       with_rst;
    logic       collecting;
    logic       present_ok;

    assign accept       = (state == SQ_OFF) && start;
    assign present_ok   = !with_rst || eng_presence;
    assign eng_reset_go = (state == SQ_RESET);
    assign eng_xfer_go  = (state == SQ_SEND) && eng_done && present_ok;
    assign launch       = (state == SQ_READ) && !collecting && eng_done;
    assign busy         = (state != SQ_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_OFF;
            with_rst   <= 1'b0;
            collecting <= 1'b0;
            rsp_valid  <= 1'b0;
            no_device  <= 1'b0;
        end else begin
            case (state)
                SQ_OFF: begin
                    if (start) begin
                        state      <= want_reset ? SQ_RESET : SQ_SEND;
                        with_rst   <= want_reset;
                        collecting <= 1'b0;
                        rsp_valid  <= 1'b0;
                        no_device  <= 1'b0;
                    end else if (clear_ready) begin
                        rsp_valid  <= 1'b0;
                    end
                end
                SQ_RESET: state <= SQ_SEND;
                SQ_SEND: begin
                    if (eng_done) begin
                        if (present_ok) begin
                            state <= SQ_READ;
                        end else begin
                            no_device <= 1'b1;
                            state     <= SQ_OFF;
                        end
                    end
                end
                SQ_READ: begin
                    if (launch)
                        collecting <= 1'b1;
                    if (collecting && gather_finish) begin
                        rsp_valid <= 1'b1;
                        state     <= SQ_OFF;
                    end
                end
                default: state <= SQ_OFF;
            endcase
        end
    end

endmodule

// File: rtl/owseq_top.sv
module owseq_top #(
    parameter int BUF_SLOTS = 128,
    parameter int CMD_MAX   = 4,
    parameter int RD_MAX    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic                              want_reset,
    input  logic [CMD_MAX*8-1:0]              cmd_data,
    input  logic [$clog2(CMD_MAX+1)-1:0]      cmd_len,
    input  logic [$clog2(RD_MAX+1)-1:0]       rd_len,
    input  logic [$clog2(BUF_SLOTS)-1:0]      rd_offset,
    input  logic                              clear_ready,
    input  logic                              eng_done,
    input  logic                              eng_presence,
    input  logic [$clog2(BUF_SLOTS)-1:0]      eng_slot_idx,
    input  logic                              cap_bit,
    output logic                              eng_reset_go,
    output logic                              eng_xfer_go,
    output logic [$clog2(BUF_SLOTS):0]        eng_slot_count,
    output logic                              eng_slot_bit,
    output logic [$clog2(BUF_SLOTS)-1:0]      cap_addr,
    output logic [RD_MAX*8-1:0]               rsp_data,
    output logic                              rsp_valid,
    output logic                              no_device,
    output logic                              busy
);
    import owseq_pkg::*;

    localparam int IDX_W = $clog2(BUF_SLOTS);
    localparam int CNT_W = IDX_W + 1;
    localparam int CL_W  = $clog2(CMD_MAX + 1);
    localparam int RL_W  = $clog2(RD_MAX + 1);
    localparam int CMD_W = CMD_MAX * 8;

    logic             accept;
    logic             launch;
    logic             finish;
    logic [CMD_W-1:0] cmd_q;
    logic [CL_W-1:0]  cmd_len_q;
    logic [RL_W-1:0]  rd_len_q;
    logic [IDX_W-1:0] offset_q;
    logic [CNT_W-1:0] span;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            cmd_len_q <= '0;
            rd_len_q  <= '0;
            offset_q  <= '0;
        end else if (accept) begin
            cmd_q     <= cmd_data;
            cmd_len_q <= (int'(cmd_len) > CMD_MAX) ? CL_W'(CMD_MAX) : cmd_len;
            rd_len_q  <= (int'(rd_len)  > RD_MAX)  ? RL_W'(RD_MAX)  : rd_len;
            offset_q  <= rd_offset;
        end
    end

    assign span = CNT_W'(clip_span(int'(offset_q), 8 * int'(rd_len_q), BUF_SLOTS));

    owseq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .want_reset   (want_reset),
        .clear_ready  (clear_ready),
        .eng_done     (eng_done),
        .eng_presence (eng_presence),
        .gather_finish(finish),
        .accept       (accept),
        .launch       (launch),
        .eng_reset_go (eng_reset_go),
        .eng_xfer_go  (eng_xfer_go),
        .busy         (busy),
        .rsp_valid    (rsp_valid),
        .no_device    (no_device)
    );

    owseq_slot_feed #(
        .BUF_SLOTS(BUF_SLOTS), .CMD_MAX(CMD_MAX), .RD_MAX(RD_MAX)
    ) u_feed (
        .cmd_q     (cmd_q),
        .cmd_len_q (cmd_len_q),
        .rd_len_q  (rd_len_q),
        .slot_idx  (eng_slot_idx),
        .slot_bit  (eng_slot_bit),
        .slot_count(eng_slot_count)
    );

    owseq_gather #(
        .BUF_SLOTS(BUF_SLOTS), .RD_MAX(RD_MAX)
    ) u_gather (
        .clk     (clk),
        .rst     (rst),
        .wipe    (accept),
        .launch  (launch),
        .first   (offset_q),
        .span    (span),
        .cap_bit (cap_bit),
        .cap_addr(cap_addr),
        .rsp     (rsp_data),
        .finish  (finish)
    );

endmodule

// File: rtl/owseq_checker.sv
module owseq_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic clear_ready,
    input logic busy,
    input logic rsp_valid,
    input logic no_device,
    input logic eng_reset_go,
    input logic eng_xfer_go,
    input logic eng_done
);
    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (rst) !(rsp_valid && no_device)); // R9
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (busy && !rsp_valid && !no_device)); // R9
    AST_RESET_GO_ONE: assert property (@(posedge clk) disable iff (rst) eng_reset_go |=> !eng_reset_go); // R2
    AST_GO_APART: assert property (@(posedge clk) disable iff (rst) !(eng_reset_go && eng_xfer_go)); // R2
    AST_XFER_AFTER_DONE: assert property (@(posedge clk) disable iff (rst) eng_xfer_go |-> eng_done); // R2
    AST_XFER_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) eng_xfer_go |-> busy); // R10
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst) no_device |-> !busy); // R3
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !clear_ready && !start) |=> rsp_valid); // R7
    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst) (rsp_valid && clear_ready) |=> !rsp_valid); // R7
endmodule

bind owseq_top owseq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .clear_ready (clear_ready),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .no_device   (no_device),
    .eng_reset_go(eng_reset_go),
    .eng_xfer_go (eng_xfer_go),
    .eng_done    (eng_done)
);

// File: tb/owseq_top_test.sv
module owseq_top_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         want_reset = 1'b0;
    logic [31:0]  cmd_data = '0;
    logic [2:0]   cmd_len = '0;
    logic [3:0]   rd_len = '0;
    logic [6:0]   rd_offset = '0;
    logic         clear_ready = 1'b0;
    logic         eng_done;
    logic         eng_presence;
    logic [6:0]   eng_slot_idx;
    logic         cap_bit;
    logic         eng_reset_go;
    logic         eng_xfer_go;
    logic [7:0]   eng_slot_count;
    logic         eng_slot_bit;
    logic [6:0]   cap_addr;
    logic [63:0]  rsp_data;
    logic         rsp_valid;
    logic         no_device;
    logic         busy;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    owseq_top uut (
        .clk(clk), .rst(rst), .start(start), .want_reset(want_reset),
        .cmd_data(cmd_data), .cmd_len(cmd_len), .rd_len(rd_len),
        .rd_offset(rd_offset), .clear_ready(clear_ready),
        .eng_done(eng_done), .eng_presence(eng_presence),
        .eng_slot_idx(eng_slot_idx), .cap_bit(cap_bit),
        .eng_reset_go(eng_reset_go), .eng_xfer_go(eng_xfer_go),
        .eng_slot_count(eng_slot_count), .eng_slot_bit(eng_slot_bit),
        .cap_addr(cap_addr), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .no_device(no_device), .busy(busy)
    );

    // ---------------- bit-slot engine model ----------------
    logic         dev_present = 1'b1;
    logic [127:0] devpat = '0;
    logic [127:0] cap = '0;
    logic [127:0] txrec = '0;
    logic [7:0]   m_n = '0;
    logic [7:0]   m_idx = '0;
    logic [7:0]   rec_count = '0;
    logic [1:0]   m_mode = '0;
    logic [3:0]   m_tmr = '0;
    logic         m_done = 1'b1;
    logic         m_pres = 1'b0;
    int           resets = 0;
    int           xfers = 0;

    assign eng_done     = m_done;
    assign eng_presence = m_pres;
    assign eng_slot_idx = m_idx[6:0];
    assign cap_bit      = cap[cap_addr];

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= 2'd0;
            m_done <= 1'b1;
            m_pres <= 1'b0;
        end else begin
            case (m_mode)
                2'd0: begin
                    if (eng_reset_go) begin
                        m_done <= 1'b0; m_pres <= 1'b0; m_tmr <= 4'd4;
                        m_mode <= 2'd1; resets <= resets + 1;
                    end else if (eng_xfer_go) begin
                        m_done <= 1'b0; m_n <= eng_slot_count; m_idx <= '0;
                        rec_count <= eng_slot_count; cap <= '0; txrec <= '0;
                        m_mode <= 2'd2; xfers <= xfers + 1;
                    end
                end
                2'd1: begin
                    m_tmr <= m_tmr - 1'b1;
                    if (m_tmr == 4'd0) begin
                        m_done <= 1'b1; m_pres <= dev_present; m_mode <= 2'd0;
                    end
                end
                default: begin
                    if (m_idx == m_n) begin
                        m_done <= 1'b1; m_mode <= 2'd0;
                    end else begin
                        txrec[m_idx[6:0]] <= eng_slot_bit;
                        cap[m_idx[6:0]]   <= eng_slot_bit & devpat[m_idx[6:0]];
                        m_idx <= m_idx + 1'b1;
                    end
                end
            endcase
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(!busy, "R10 busy falls at end", 128'(busy), 128'd0);
    endtask

    task automatic run_txn(input bit wr, input bit pres, input int cl, input int rl, input int off,
                           input logic [31:0] cmdv, input logic [127:0] dp, input bit poke);
        int rb = resets;
        int xb = xfers;
        int total;
        int span;
        logic [127:0] exp_tx;
        logic [127:0] exp_cap;
        logic [63:0]  exp_rsp;
        dev_present = pres;
        devpat = dp;
        @(negedge clk);
        want_reset = wr; cmd_data = cmdv; cmd_len = 3'(cl); rd_len = 4'(rl);
        rd_offset = 7'(off); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !rsp_valid && !no_device, "R9 flags cleared after start",
              {125'd0, busy, rsp_valid, no_device}, 128'd4);
        if (poke) begin
            @(negedge clk);
            cmd_data = ~cmdv; cmd_len = 3'd1; rd_len = 4'd2; rd_offset = 7'd5;
            want_reset = !wr; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();
        check(resets == rb + (wr ? 1 : 0), "R2 reset pulse count", 128'(resets - rb), 128'(wr));
        if (wr && !pres) begin
            check(no_device && !rsp_valid && xfers == xb, "R3 abort without transfer",
                  {125'd0, no_device, rsp_valid, (xfers != xb)}, 128'd4);
            return;
        end
        check(xfers == xb + 1, poke ? "R8 one transfer only" : "R4 one transfer",
              128'(xfers - xb), 128'd1);
        total = 8 * (cl + rl);
        if (total > 128) total = 128;
        exp_tx = '0;
        exp_cap = '0;
        for (int p = 0; p < total; p++) begin
            exp_tx[p]  = (p < 8 * cl) ? cmdv[p] : 1'b1;
            exp_cap[p] = exp_tx[p] & dp[p];
        end
        check(rec_count == 8'(total), "R4 slot count", 128'(rec_count), 128'(total));
        check(txrec == exp_tx, "R4 slot stream", txrec, exp_tx);
        span = 8 * rl;
        if (span > 128 - off) span = 128 - off;
        exp_rsp = '0;
        for (int k = 0; k < span; k++)
            exp_rsp[k] = exp_cap[off + k];
        check(rsp_data == exp_rsp, (span < 8 * rl) ? "R6 clipped extraction" : "R5 response bits",
              128'(rsp_data), 128'(exp_rsp));
        check(rsp_valid && !no_device, "R7 data ready set", {126'd0, rsp_valid, no_device}, 128'd2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 128'd0, 128'd1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check(!busy && !rsp_valid && !no_device && !eng_reset_go && !eng_xfer_go && rsp_data == '0,
              "R1 reset state", {122'd0, busy, rsp_valid, no_device, eng_reset_go, eng_xfer_go, |rsp_data},
              128'd0);

        // R3: no device answers the reset
        run_txn(1'b1, 1'b0, 2, 8, 16, 32'h0000_33CC, {4{32'hF0F0_A5A5}}, 1'b0);
        // R9: next start clears the error
        run_txn(1'b1, 1'b1, 2, 8, 16, 32'h0000_33CC, {4{32'h1234_5678}}, 1'b0);
        // R2: no reset requested, presence low is ignored
        run_txn(1'b0, 1'b0, 1, 2, 8, 32'h0000_00BE, {4{32'hDEAD_BEEF}}, 1'b0);
        // R8: start during busy ignored
        run_txn(1'b1, 1'b1, 3, 4, 24, 32'h00A1_B2C3, {4{32'hC001_D00D}}, 1'b1);

        // R7: ready holds, then clear_ready drops it
        repeat (10) @(negedge clk);
        check(rsp_valid, "R7 ready stays set", 128'(rsp_valid), 128'd1);
        clear_ready = 1'b1;
        @(negedge clk);
        clear_ready = 1'b0;
        check(!rsp_valid && !busy, "R7 ready cleared", 128'(rsp_valid), 128'd0);

        // Sweep: command length, read length and offsets
        for (int cl = 0; cl <= 4; cl++) begin
            for (int rl = 0; rl <= 8; rl++) begin
                for (int oi = 0; oi < 4; oi++) begin
                    int off;
                    logic [31:0] seed;
                    case (oi)
                        0: off = 0;
                        1: off = 8 * cl;
                        2: off = 120;
                        default: off = 127;
                    endcase
                    seed = {16'h0, 4'(cl), 4'(rl), 8'(off)};
                    run_txn(((cl + rl + oi) % 2) == 0, 1'b1, cl, rl, off,
                            (seed * 32'h0100_0193) ^ 32'h5AC3_33CC,
                            {32'h9E37_79B9 ^ seed, 32'h7F4A_7C15 + seed, ~(seed * 3), seed ^ 32'h5555_AAAA},
                            1'b0);
                end
            end
        end
        summary();
    end

endmodule